// File: doc/BRIEF.md
# Framed Link Playback Buffer

This block plays a stored sequence of 32-bit words toward one serial transmitter. Every word is stored with a 4-bit mask that has one bit per byte. A set bit marks that byte as a comma control character. Playout is grouped into frames of `FRAME_LEN` consecutive words, and one frame goes out in each bunch-crossing period of `BC_CYCLES` clock cycles. The word slots of a period come first, and the idle slots follow them.

A host port loads the data and mask memories. While `run` is low, the block sends frame 0 in every period, which gives the far receiver a fixed pattern to align to. When `run` is high, frames follow each other in address order. When playout reaches the last complete frame, the next frame is frame 0 again, so the partial frame at the top of memory is never sent. A bunch-crossing reset makes the next frame boundary start from frame 0. A frame-sync pulse forces a frame boundary at once, which lines the transmit frame up with the bunch-crossing cycle.

The memory holds 2^`ADDR_W` words. The default is small, and a full-size instance uses `ADDR_W` = 13, which gives 8192 words and 1170 complete frames of seven words. The output `frames_avail` reports the number of complete frames that fit.

Top module: `pb_playback`

## Requirements
- R1: While reset is high, `out_valid`, `out_first`, `out_data` and `out_ctrl` are all zero.
- R2: In each bunch-crossing period, `out_valid` is high for exactly `FRAME_LEN` consecutive cycles and low for the remaining `BC_CYCLES - FRAME_LEN` cycles. `out_first` is high only on the first word of a frame.
- R3: Word k of frame f carries the memory word at address f*`FRAME_LEN` + k.
- R4: If `run` is low at a frame boundary, the next frame sent is frame 0.
- R5: If `run` is high and no restart condition applies, each frame is the one after the previous frame.
- R6: The frame after the last complete frame, floor(2^`ADDR_W` / `FRAME_LEN`) - 1, is frame 0. Words above the last complete frame never appear.
- R7: A one-cycle `bcr` pulse makes the first frame boundary after it restart at frame 0. Playout then continues from frame 1 while `run` is high.
- R8: A `frame_sync` pulse sampled at a clock edge forces a frame boundary there. `out_first` goes high two edges after the pulse is sampled, carrying the first word of the selected frame.
- R9: Bit i of `out_ctrl` is the mask bit stored for byte i of `out_data`, where byte i is bits 8i+7 down to 8i.
- R10: `frames_avail` equals floor(2^`ADDR_W` / `FRAME_LEN`).
- R11: A host write with `wr_en` high stores `wr_data` and `wr_mask` at `wr_addr`. Later playout of that address shows the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 32 | Word to store |
| wr_mask | input | 4 | Per-byte control-character mask to store |
| run | input | 1 | High to advance through frames; low to repeat frame 0 |
| bcr | input | 1 | Bunch-crossing reset pulse |
| frame_sync | input | 1 | Pulse that forces a frame boundary |
| out_data | output | 32 | Played word |
| out_ctrl | output | 4 | Per-byte control-character flags of the played word |
| out_valid | output | 1 | High while a word slot is being sent |
| out_first | output | 1 | High on the first word of each frame |
| frames_avail | output | ADDR_W+1 | Number of complete frames in memory |

## Verification
A wrong frame index or base address appears at the ports in the next frame. Every word of that frame then carries data from the wrong address, and the scoreboard sees this within one bunch-crossing period. A slipped phase counter shows up at the next `out_first` as a run of valid words that is not seven long or a gap of the wrong length. A lost bunch-crossing reset or a missing wrap gives a wrong frame at a boundary the bench knows in advance.

// File: rtl/pb_pkg.sv
package pb_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [LANES-1:0]  ctrl;
    } pb_word_t;

    typedef struct packed {
        logic valid;
        logic first;
    } pb_slot_t;

    function automatic int pb_frames_fit(input int depth, input int flen);
        return depth / flen;
    endfunction

endpackage

// File: rtl/pb_store.sv
module pb_store
    import pb_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    output pb_word_t          rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] dmem [DEPTH];
        logic              cmem [DEPTH];
        logic [LANE_W-1:0] d_q;
        logic              c_q;

        always_ff @(posedge clk) begin
            if (wr_en) begin
                dmem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
                cmem[wr_addr] <= wr_mask[g];
            end
            d_q <= dmem[rd_addr];
            c_q <= cmem[rd_addr];
        end

        assign rd_word.data[g*LANE_W +: LANE_W] = d_q;
        assign rd_word.ctrl[g]                  = c_q;
    end

endmodule

// File: rtl/pb_phase.sv
module pb_phase #(
    parameter int BC_CYCLES = 8,
    parameter int FRAME_LEN = 7,
    localparam int PH_W     = (BC_CYCLES > 1) ? $clog2(BC_CYCLES) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_sync,
    output logic [PH_W-1:0] ph,
    output logic            boundary,
    output logic            slot_active,
    output logic            slot_first
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BC_CYCLES - 1);
    localparam logic [PH_W-1:0] PH_WORDS = PH_W'(FRAME_LEN);

    assign boundary    = frame_sync || (ph == PH_LAST);
    assign slot_active = (ph < PH_WORDS);
    assign slot_first  = (ph == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= '0;
        end else if (boundary) begin
            ph <= '0;
        end else begin
            ph <= ph + 1'b1;
        end
    end

    a_r8_sync_restarts_phase: assert property (@(posedge clk) disable iff (rst)
        frame_sync |=> (ph == '0));

    a_r2_phase_in_period: assert property (@(posedge clk) disable iff (rst)
        ph <= PH_LAST);

endmodule

// File: rtl/pb_sequencer.sv
module pb_sequencer #(
    parameter int ADDR_W    = 10,
    parameter int FRAME_LEN = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              bcr,
    input  logic              boundary,
    output logic [ADDR_W-1:0] base
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NFR   = pb_pkg::pb_frames_fit(DEPTH, FRAME_LEN);
    localparam int FI_W  = (NFR > 1) ? $clog2(NFR) : 1;
    localparam logic [FI_W-1:0] FI_LAST = FI_W'(NFR - 1);

    logic [FI_W-1:0] fidx;
    logic            bcr_pend;
    logic            restart;

    assign restart = !run || bcr || bcr_pend || (fidx == FI_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            fidx     <= '0;
            base     <= '0;
            bcr_pend <= 1'b0;
        end else begin
            if (boundary) begin
                bcr_pend <= 1'b0;
                if (restart) begin
                    fidx <= '0;
                    base <= '0;
                end else begin
                    fidx <= fidx + 1'b1;
                    base <= base + ADDR_W'(FRAME_LEN);
                end
            end else if (bcr) begin
                bcr_pend <= 1'b1;
            end
        end
    end

    a_r6_index_in_range: assert property (@(posedge clk) disable iff (rst)
        fidx <= FI_LAST);

    a_r6_wrap_after_last: assert property (@(posedge clk) disable iff (rst)
        (boundary && fidx == FI_LAST) |=> (fidx == '0));

    a_r4_idle_holds_first: assert property (@(posedge clk) disable iff (rst)
        (boundary && !run) |=> (base == '0));

    a_r7_bcr_restarts: assert property (@(posedge clk) disable iff (rst)
        (boundary && bcr) |=> (fidx == '0));

    a_r3_base_tracks_index: assert property (@(posedge clk) disable iff (rst)
        int'(base) == int'(fidx) * FRAME_LEN);

endmodule

// File: rtl/pb_playback.sv
module pb_playback
    import pb_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int FRAME_LEN = 7,
    parameter int BC_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        wr_mask,
    input  logic              run,
    input  logic              bcr,
    input  logic              frame_sync,
    output logic [31:0]       out_data,
    output logic [3:0]        out_ctrl,
    output logic              out_valid,
    output logic              out_first,
    output logic [ADDR_W:0]   frames_avail
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NFR   = pb_frames_fit(DEPTH, FRAME_LEN);
    localparam int PH_W  = (BC_CYCLES > 1) ? $clog2(BC_CYCLES) : 1;

    logic [PH_W-1:0]   ph;
    logic              boundary;
    logic              slot_active;
    logic              slot_first;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] rd_addr;
    pb_word_t          rd_word;
    pb_slot_t          slot_q;

    pb_phase #(
        .BC_CYCLES (BC_CYCLES),
        .FRAME_LEN (FRAME_LEN)
    ) u_phase (
        .clk         (clk),
        .rst         (rst),
        .frame_sync  (frame_sync),
        .ph          (ph),
        .boundary    (boundary),
        .slot_active (slot_active),
        .slot_first  (slot_first)
    );

    pb_sequencer #(
        .ADDR_W    (ADDR_W),
        .FRAME_LEN (FRAME_LEN)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .bcr      (bcr),
        .boundary (boundary),
        .base     (base)
    );

    assign rd_addr = base + ADDR_W'(ph);

    pb_store #(
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            slot_q.valid <= slot_active;
            slot_q.first <= slot_active && slot_first;
        end
    end

    assign out_valid    = slot_q.valid;
    assign out_first    = slot_q.first;
    assign out_data     = slot_q.valid ? rd_word.data : '0;
    assign out_ctrl     = slot_q.valid ? rd_word.ctrl : '0;
    assign frames_avail = (ADDR_W+1)'(NFR);

    a_r2_first_is_valid: assert property (@(posedge clk) disable iff (rst)
        out_first |-> out_valid);

    a_r2_valid_starts_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> out_first);

    a_r8_first_after_sync: assert property (@(posedge clk) disable iff (rst)
        frame_sync |=> ##1 out_first);

endmodule

// File: tb/sim_pb_playback.sv
module sim_pb_playback;
    localparam int AW    = 6;
    localparam int FL    = 7;
    localparam int BCC   = 8;
    localparam int DEPTH = 1 << AW;
    localparam int NFR   = DEPTH / FL;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [3:0]    wr_mask = '0;
    logic          run = 1'b0;
    logic          bcr = 1'b0;
    logic          frame_sync = 1'b0;
    logic [31:0]   out_data;
    logic [3:0]    out_ctrl;
    logic          out_valid;
    logic          out_first;
    logic [AW:0]   frames_avail;

    pb_playback #(.ADDR_W(AW), .FRAME_LEN(FL), .BC_CYCLES(BCC)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask), .run(run), .bcr(bcr),
        .frame_sync(frame_sync), .out_data(out_data), .out_ctrl(out_ctrl),
        .out_valid(out_valid), .out_first(out_first), .frames_avail(frames_avail)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    bit    mon_en = 1'b0;
    logic [31:0] sh_d [DEPTH];
    logic [3:0]  sh_m [DEPTH];
    int    q_idx [$];
    string q_req [$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat_d(input int a);
        return {8'(a), 8'(~a), 8'(a + 64), 8'(a ^ 90)};
    endfunction

    function automatic logic [3:0] pat_m(input int a);
        return 4'((a * 5 + 3) % 16);
    endfunction

    // Called at posedge+2; returns at the next posedge+2.
    task automatic put(input int a, input logic [31:0] d, input logic [3:0] m);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_mask = m;
        sh_d[a] = d; sh_m[a] = m;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic expect_frame(input int idx, input string req);
        q_idx.push_back(idx);
        q_req.push_back(req);
    endtask

    // Scoreboard monitor: pops one expected frame per out_first.
    int    vlen = 0;
    int    gap = 0;
    bit    have_prev = 1'b0;
    int    cur_idx = -1;
    string cur_req = "R3";
    always @(negedge clk) begin
        int a;
        if (mon_en) begin
            if (out_valid) begin
                if (out_first) begin
                    if (have_prev) begin
                        check(vlen == FL, "R2", "words per frame", 32'(vlen), 32'(FL));
                        check(gap == BCC - FL, "R2", "idle slots", 32'(gap), 32'(BCC - FL));
                    end
                    have_prev = 1'b1; vlen = 0; gap = 0;
                    if (q_idx.size() == 0) begin
                        check(1'b0, "R5", "unexpected frame", 32'(1), 32'(0));
                        cur_idx = -1;
                    end else begin
                        cur_idx = q_idx.pop_front();
                        cur_req = q_req.pop_front();
                    end
                end
                if (cur_idx >= 0 && vlen < FL) begin
                    a = cur_idx * FL + vlen;
                    check(out_data == sh_d[a], cur_req, "word data", out_data, sh_d[a]);
                    check(out_ctrl == sh_m[a], "R9", "byte flags", 32'(out_ctrl), 32'(sh_m[a]));
                end
                vlen++;
            end else begin
                gap++;
            end
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check(out_valid == 1'b0, "R1", "valid in reset", 32'(out_valid), 32'(0));
        check(out_first == 1'b0, "R1", "first in reset", 32'(out_first), 32'(0));
        check(out_data == '0, "R1", "data in reset", out_data, 32'(0));
        check(out_ctrl == '0, "R1", "flags in reset", 32'(out_ctrl), 32'(0));
        rst = 1'b0;
        // R10: complete frame count
        check(int'(frames_avail) == NFR, "R10", "frames_avail", 32'(frames_avail), 32'(NFR));
        for (int a = 0; a < DEPTH; a++) put(a, pat_d(a), pat_m(a));
        // R11: overwrite a word of frame 0 before playout
        put(3, 32'hDEAD_BEEF, 4'hA);
        frame_sync = 1'b1;
        @(posedge clk); #2;          // E0
        frame_sync = 1'b0;
        @(negedge clk); #1;
        expect_frame(0, "R4");
        expect_frame(1, "R5");
        expect_frame(2, "R5");
        expect_frame(3, "R3");
        expect_frame(4, "R3");
        expect_frame(5, "R11");
        expect_frame(6, "R3");
        expect_frame(7, "R3");
        expect_frame(8, "R6");
        expect_frame(0, "R6");
        expect_frame(1, "R5");
        expect_frame(2, "R5");
        expect_frame(0, "R7");
        expect_frame(1, "R7");
        expect_frame(0, "R4");
        expect_frame(0, "R4");
        expect_frame(0, "R4");
        mon_en = 1'b1;
        repeat (4) @(posedge clk); #2;   // E4
        run = 1'b1;
        repeat (6) @(posedge clk); #2;   // E10: R11 write during playout
        put(40, 32'hC0FF_EE00, 4'h5);
        repeat (81) @(posedge clk); #2;  // E92: R7 pulse mid-period
        bcr = 1'b1;
        @(posedge clk); #2;
        bcr = 1'b0;
        repeat (15) @(posedge clk); #2;  // E108
        run = 1'b0;
        repeat (24) @(posedge clk); #2;  // E132
        check(q_idx.size() == 0, "R5", "frames left unplayed", 32'(q_idx.size()), 32'(0));
        mon_en = 1'b0;
        // R8: forced boundary in the middle of a frame
        frame_sync = 1'b1;
        @(posedge clk); #2;
        frame_sync = 1'b0;
        @(negedge clk);
        check(out_first == 1'b0, "R8", "first one edge after sync", 32'(out_first), 32'(0));
        @(negedge clk);
        check(out_first == 1'b1, "R8", "first two edges after sync", 32'(out_first), 32'(1));
        check(out_data == sh_d[0], "R8", "word after sync", out_data, sh_d[0]);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule